// File: doc/BRIEF.md
# Reduced-Instruction Test Access Port Controller

This block is a serial test access port in the boundary-scan style. It is clocked by a test clock, steered by a mode-select line and fed by a serial data input, and it returns a serial data output. A standard sixteen-state controller walks the instruction-scan and data-scan sequences. A three-bit instruction chooses which data register sits between the serial input and the serial output. The data registers are a single bypass bit, a 32-bit identification word and a boundary register of configurable length that captures the functional pin values.

The instruction set is deliberately short. None of the instructions can drive values onto the functional pins. The update step of a data scan therefore changes nothing: for the sampling instructions it acts like a pause. One instruction, sample-and-float, samples the pins and also raises an output-disable line. The surrounding chip uses that line to put its functional outputs into high impedance. Serial output changes only on the falling test-clock edge, and its enable is high only while a register is shifting.

Top module: `tap_reduced_top`

## Requirements
- R1: An active-low `trstN` resets asynchronously, and five rising `tck` edges with `tms` high reach reset from any state. Reset loads the identification instruction (code 001) into the instruction register on the edge that enters reset, and `outDisable` drops at once.
- R2: The controller follows the standard sixteen-state graph on rising `tck` edges, with `tms` and `tdi` sampled there. This includes pausing a data scan (Exit1, Pause, Exit2) and resuming it without losing shifted bits.
- R3: Capture-IR loads the pattern 001 into the instruction shift register, so the first three bits out of an instruction scan are 1, 0, 0.
- R4: Under instruction 001 the data path is 32 bits long. It captures the `ID_VALUE` parameter with bit 0 forced to 1, and the word is shifted out least significant bit first.
- R5: Code 111 and the unassigned codes 011, 101 and 110 select a one-bit register. This register captures 0, so `tdi` reappears on `tdo` one shift later.
- R6: Codes 000, 010 and 100 select the boundary register. Capture-DR loads `pinCapture`, the bits leave least significant first, and `tdi` data reappears after `BSR_LEN` shifts.
- R7: `outDisable` is high exactly while the current instruction is 010. It rises only from the Update-IR state, and it is low for every other code.
- R8: Update-DR has no effect. `outDisable` keeps its value through it, and data shifted into the boundary register is not retained: the next capture reloads the pin values.
- R9: `tdo` and `tdoEn` change only on the falling `tck` edge. `tdoEn` is high only in Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| pinCapture | input | BSR_LEN | Functional pin values captured into the boundary register |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdoEn | output | 1 | High while tdo carries valid shift data; otherwise the pad floats |
| outDisable | output | 1 | Forces functional outputs to high impedance while sample-and-float is current |

## Verification
The assertions check the following on every cycle:
- reset always holds the identification instruction;
- five high `tms` samples always land in reset;
- Capture-IR always leaves 001 in the instruction shifter;
- `outDisable` only ever rises out of Update-IR and stays steady through Update-DR;
- the serial-output enable is never high outside a shift state.

Other behaviour can only be shown by the bench's scenarios, which compare each scan against expected values:
- the length and captured contents of the register each of the eight codes selects;
- bits surviving a paused scan;
- pin data reloaded after an update;
- `tdo` holding across a rising edge.

// File: rtl/tap_pkg.sv
package tap_pkg;

  localparam int IR_W = 3;
  localparam int ID_W = 32;

  typedef enum logic [3:0] {
    ST_RESET    = 4'd0,
    ST_IDLE     = 4'd1,
    ST_SEL_DR   = 4'd2,
    ST_CAP_DR   = 4'd3,
    ST_SH_DR    = 4'd4,
    ST_EX1_DR   = 4'd5,
    ST_PAUSE_DR = 4'd6,
    ST_EX2_DR   = 4'd7,
    ST_UPD_DR   = 4'd8,
    ST_SEL_IR   = 4'd9,
    ST_CAP_IR   = 4'd10,
    ST_SH_IR    = 4'd11,
    ST_EX1_IR   = 4'd12,
    ST_PAUSE_IR = 4'd13,
    ST_EX2_IR   = 4'd14,
    ST_UPD_IR   = 4'd15
  } tapState_t;

  localparam logic [IR_W-1:0] OP_EXTEST      = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE      = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLE_FLT  = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE      = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS      = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 3'b001;

  typedef enum logic [1:0] {
    DR_BYPASS   = 2'd0,
    DR_IDENT    = 2'd1,
    DR_BOUNDARY = 2'd2
  } drSel_t;

  // strobes from control to datapath, valid for the current state
  typedef struct packed {
    logic goReset;   // next edge enters reset
    logic capIr;
    logic shIr;
    logic updIr;
    logic capDr;
    logic shDr;
  } tapStrobes_t;

endpackage

// File: rtl/tap_shreg.sv
module tap_shreg #(
  parameter int W = 8
) (
  input  logic         tck,
  input  logic         trstN,
  input  logic         capEn,
  input  logic         shEn,
  input  logic [W-1:0] capVal,
  input  logic         sin,
  output logic [W-1:0] q
);

  generate
    if (W == 1) begin : g_single
      always_ff @(posedge tck or negedge trstN) begin
        if (!trstN)     q <= '0;
        else if (capEn) q <= capVal;
        else if (shEn)  q <= sin;
      end
    end else begin : g_multi
      always_ff @(posedge tck or negedge trstN) begin
        if (!trstN)     q <= '0;
        else if (capEn) q <= capVal;
        else if (shEn)  q <= {sin, q[W-1:1]};
      end
    end
  endgenerate

endmodule

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import tap_pkg::*;
(
  input  logic        tck,
  input  logic        trstN,
  input  logic        tms,
  output tapState_t   stateQ,
  output tapStrobes_t strobes
);

  tapState_t stateNext;

  always_comb begin
    unique case (stateQ)
      ST_RESET:    stateNext = tms ? ST_RESET    : ST_IDLE;
      ST_IDLE:     stateNext = tms ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_DR:   stateNext = tms ? ST_SEL_IR   : ST_CAP_DR;
      ST_CAP_DR:   stateNext = tms ? ST_EX1_DR   : ST_SH_DR;
      ST_SH_DR:    stateNext = tms ? ST_EX1_DR   : ST_SH_DR;
      ST_EX1_DR:   stateNext = tms ? ST_UPD_DR   : ST_PAUSE_DR;
      ST_PAUSE_DR: stateNext = tms ? ST_EX2_DR   : ST_PAUSE_DR;
      ST_EX2_DR:   stateNext = tms ? ST_UPD_DR   : ST_SH_DR;
      ST_UPD_DR:   stateNext = tms ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_IR:   stateNext = tms ? ST_RESET    : ST_CAP_IR;
      ST_CAP_IR:   stateNext = tms ? ST_EX1_IR   : ST_SH_IR;
      ST_SH_IR:    stateNext = tms ? ST_EX1_IR   : ST_SH_IR;
      ST_EX1_IR:   stateNext = tms ? ST_UPD_IR   : ST_PAUSE_IR;
      ST_PAUSE_IR: stateNext = tms ? ST_EX2_IR   : ST_PAUSE_IR;
      ST_EX2_IR:   stateNext = tms ? ST_UPD_IR   : ST_SH_IR;
      ST_UPD_IR:   stateNext = tms ? ST_SEL_DR   : ST_IDLE;
      default:     stateNext = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) stateQ <= ST_RESET;
    else        stateQ <= stateNext;
  end

  always_comb begin
    strobes.goReset = (stateNext == ST_RESET);
    strobes.capIr   = (stateQ == ST_CAP_IR);
    strobes.shIr    = (stateQ == ST_SH_IR);
    strobes.updIr   = (stateQ == ST_UPD_IR);
    strobes.capDr   = (stateQ == ST_CAP_DR);
    strobes.shDr    = (stateQ == ST_SH_DR);
  end

endmodule

// File: rtl/tap_datapath.sv
module tap_datapath
  import tap_pkg::*;
#(
  parameter int          BSR_LEN  = 8,
  parameter logic [31:0] ID_VALUE = 32'h0A5C_3E56
) (
  input  logic               tck,
  input  logic               trstN,
  input  logic               tdi,
  input  tapStrobes_t        strobes,
  input  logic [BSR_LEN-1:0] pinCapture,
  output logic [IR_W-1:0]    irQ,
  output logic [IR_W-1:0]    irShiftQ,
  output logic               tdo,
  output logic               tdoEn,
  output logic               outDisable
);

  localparam logic [ID_W-1:0] ID_WORD = {ID_VALUE[ID_W-1:1], 1'b1};

  drSel_t             drSel;
  logic               bypassQ;
  logic [ID_W-1:0]    idQ;
  logic [BSR_LEN-1:0] bsrQ;
  logic               drBit;

  // instruction shifter and current instruction
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)             irShiftQ <= IR_CAPTURE_PAT;
    else if (strobes.capIr) irShiftQ <= IR_CAPTURE_PAT;
    else if (strobes.shIr)  irShiftQ <= {tdi, irShiftQ[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)               irQ <= OP_IDCODE;
    else if (strobes.goReset) irQ <= OP_IDCODE;
    else if (strobes.updIr)   irQ <= irShiftQ;
  end

  always_comb begin
    unique case (irQ)
      OP_IDCODE:                          drSel = DR_IDENT;
      OP_EXTEST, OP_SAMPLE_FLT, OP_SAMPLE: drSel = DR_BOUNDARY;
      default:                            drSel = DR_BYPASS;
    endcase
  end

  assign outDisable = (irQ == OP_SAMPLE_FLT);

  // data registers; no update stage exists behind any of them
  tap_shreg #(.W(1)) uBypass (
    .tck    (tck),
    .trstN  (trstN),
    .capEn  (strobes.capDr && drSel == DR_BYPASS),
    .shEn   (strobes.shDr  && drSel == DR_BYPASS),
    .capVal (1'b0),
    .sin    (tdi),
    .q      (bypassQ)
  );

  tap_shreg #(.W(ID_W)) uIdent (
    .tck    (tck),
    .trstN  (trstN),
    .capEn  (strobes.capDr && drSel == DR_IDENT),
    .shEn   (strobes.shDr  && drSel == DR_IDENT),
    .capVal (ID_WORD),
    .sin    (tdi),
    .q      (idQ)
  );

  tap_shreg #(.W(BSR_LEN)) uBoundary (
    .tck    (tck),
    .trstN  (trstN),
    .capEn  (strobes.capDr && drSel == DR_BOUNDARY),
    .shEn   (strobes.shDr  && drSel == DR_BOUNDARY),
    .capVal (pinCapture),
    .sin    (tdi),
    .q      (bsrQ)
  );

  always_comb begin
    unique case (drSel)
      DR_IDENT:    drBit = idQ[0];
      DR_BOUNDARY: drBit = bsrQ[0];
      default:     drBit = bypassQ;
    endcase
  end

  // serial output retimed to the falling edge
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdo   <= strobes.shIr ? irShiftQ[0] : drBit;
      tdoEn <= strobes.shIr || strobes.shDr;
    end
  end

endmodule

// File: rtl/tap_reduced_top.sv
module tap_reduced_top
  import tap_pkg::*;
#(
  parameter int          BSR_LEN  = 8,
  parameter logic [31:0] ID_VALUE = 32'h0A5C_3E56
) (
  input  logic               tck,
  input  logic               trstN,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pinCapture,
  output logic               tdo,
  output logic               tdoEn,
  output logic               outDisable
);

  tapState_t       stateW;
  tapStrobes_t     strobesW;
  logic [IR_W-1:0] irW;
  logic [IR_W-1:0] irShiftW;

  tap_ctrl uCtrl (
    .tck     (tck),
    .trstN   (trstN),
    .tms     (tms),
    .stateQ  (stateW),
    .strobes (strobesW)
  );

  tap_datapath #(.BSR_LEN(BSR_LEN), .ID_VALUE(ID_VALUE)) uData (
    .tck        (tck),
    .trstN      (trstN),
    .tdi        (tdi),
    .strobes    (strobesW),
    .pinCapture (pinCapture),
    .irQ        (irW),
    .irShiftQ   (irShiftW),
    .tdo        (tdo),
    .tdoEn      (tdoEn),
    .outDisable (outDisable)
  );

endmodule

// File: rtl/tap_reduced_chk.sv
module tap_reduced_chk
  import tap_pkg::*;
(
  input logic            tck,
  input logic            trstN,
  input logic            tms,
  input logic            tdoEn,
  input logic            outDisable,
  input tapState_t       stateQ,
  input logic [IR_W-1:0] irQ,
  input logic [IR_W-1:0] irShiftQ
);

  logic [2:0] onesCnt;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)             onesCnt <= '0;
    else if (!tms)          onesCnt <= '0;
    else if (onesCnt != 3'd7) onesCnt <= onesCnt + 3'd1;
  end

  p_reset_holds_id_r1: assert property (@(posedge tck) disable iff (!trstN)
    (stateQ == ST_RESET) |-> (irQ == OP_IDCODE));

  p_five_ones_reset_r2: assert property (@(posedge tck) disable iff (!trstN)
    (onesCnt >= 3'd5) |-> (stateQ == ST_RESET));

  p_capture_ir_r3: assert property (@(posedge tck) disable iff (!trstN)
    (stateQ == ST_CAP_IR) |=> (irShiftQ == IR_CAPTURE_PAT));

  p_float_from_upd_ir_r7: assert property (@(posedge tck) disable iff (!trstN)
    $rose(outDisable) |-> ($past(stateQ) == ST_UPD_IR));

  p_upd_dr_inert_r8: assert property (@(posedge tck) disable iff (!trstN)
    (stateQ == ST_UPD_DR) |=> $stable(outDisable));

  p_tdo_en_shift_r9: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn |-> (stateQ == ST_SH_DR || stateQ == ST_SH_IR));

endmodule

bind tap_reduced_top tap_reduced_chk uChk (
  .tck        (tck),
  .trstN      (trstN),
  .tms        (tms),
  .tdoEn      (tdoEn),
  .outDisable (outDisable),
  .stateQ     (stateW),
  .irQ        (irW),
  .irShiftQ   (irShiftW)
);

// File: tb/tap_reduced_top_test.sv
`timescale 1ns/1ps
module tap_reduced_top_test;

  localparam int          BSR_LEN  = 8;
  localparam logic [31:0] ID_VALUE = 32'h0A5C_3E56;
  localparam logic [31:0] ID_EXP   = 32'h0A5C_3E57;

  logic               tck = 1'b0;
  logic               trstN = 1'b0;
  logic               tms = 1'b1;
  logic               tdi = 1'b1;
  logic [BSR_LEN-1:0] pins = '0;
  logic               tdo, tdoEn, outDisable;

  int checks = 0;
  int errors = 0;

  tap_reduced_top #(.BSR_LEN(BSR_LEN), .ID_VALUE(ID_VALUE)) uut (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .pinCapture(pins),
    .tdo(tdo), .tdoEn(tdoEn), .outDisable(outDisable)
  );

  always #5 tck = ~tck;

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one TCK cycle: read tdo after the falling edge, then drive inputs for the rising edge
  task automatic clk(input logic m, input logic d, output logic o, output logic oe);
    @(negedge tck); #1;
    o = tdo; oe = tdoEn;
    tms = m; tdi = d;
    @(posedge tck); #1;
  endtask

  task automatic irScan(input logic [2:0] code, output logic [2:0] cap);
    logic o, oe;
    clk(1, 0, o, oe); clk(1, 0, o, oe); clk(0, 0, o, oe); clk(0, 0, o, oe);
    for (int i = 0; i < 3; i++) begin
      clk(i == 2, code[i], o, oe);
      cap[i] = o;
    end
    clk(1, 0, o, oe); clk(0, 0, o, oe);
  endtask

  task automatic drScan(input int n, input logic [63:0] din, output logic [63:0] dout, output logic oeAll);
    logic o, oe;
    dout = '0; oeAll = 1'b1;
    clk(1, 0, o, oe); clk(0, 0, o, oe); clk(0, 0, o, oe);
    for (int i = 0; i < n; i++) begin
      clk(i == n - 1, din[i], o, oe);
      dout[i] = o;
      oeAll &= oe;
    end
    clk(1, 0, o, oe); clk(0, 0, o, oe);
  endtask

  function automatic logic [63:0] expDr(input int len, input logic [63:0] cap, input logic [63:0] din, input int n);
    logic [63:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = (i < len) ? cap[i] : din[i - len];
    return r;
  endfunction

  initial begin
    logic [2:0]  cap;
    logic [63:0] dout;
    logic        oeAll, o, oe, a, b;
    logic [63:0] din;
    int          len;
    logic [63:0] capV;

    // reset state
    #22;
    chk(tdoEn == 1'b0, "R9 tdoEn low in reset", {63'd0, tdoEn}, 0);
    chk(outDisable == 1'b0, "R1 outDisable low in reset", {63'd0, outDisable}, 0);
    trstN = 1'b1;
    clk(0, 0, o, oe);

    // R1 R4: identification instruction is current after reset
    din = 64'h0000_00C3_0000_0000 | 64'hB5;
    drScan(40, din, dout, oeAll);
    chk(dout[39:0] == expDr(32, {32'd0, ID_EXP}, din, 40)[39:0], "R1 R4 id after reset", dout, expDr(32, {32'd0, ID_EXP}, din, 40));
    chk(oeAll == 1'b1, "R9 tdoEn high while shifting", {63'd0, oeAll}, 1);
    clk(0, 0, o, oe);
    chk(oe == 1'b0, "R9 tdoEn low in idle", {63'd0, oe}, 0);

    // sweep all eight codes
    for (int c = 0; c < 8; c++) begin
      irScan(c[2:0], cap);
      chk(cap == 3'b001, "R3 capture-ir pattern", {61'd0, cap}, 64'd1);
      chk(outDisable == (c == 2), "R7 outDisable per code", {63'd0, outDisable}, {63'd0, c == 2});
      pins = BSR_LEN'(8'h5A ^ (c * 37));
      din = 64'h9E37_79B9_7F4A_7C15 >> c;
      if (c == 1) begin len = 32; capV = {32'd0, ID_EXP}; end
      else if (c == 0 || c == 2 || c == 4) begin len = BSR_LEN; capV = {56'd0, pins}; end
      else begin len = 1; capV = '0; end
      drScan(40, din, dout, oeAll);
      chk(dout[39:0] == expDr(len, capV, din, 40)[39:0],
          (c == 1) ? "R4 ident path" : ((len == 1) ? "R5 bypass path" : "R6 boundary path"),
          dout, expDr(len, capV, din, 40));
      chk(outDisable == (c == 2), "R8 outDisable after update-dr", {63'd0, outDisable}, {63'd0, c == 2});
    end

    // R2: paused data scan under bypass keeps its bits
    irScan(3'b111, cap);
    clk(1, 0, o, oe); clk(0, 0, o, oe); clk(0, 0, o, oe);
    clk(0, 1, o, oe); a = o;          // captured 0 out, 1 in
    clk(1, 0, o, oe); b = o;          // 1 out, 0 in, to Exit1
    chk(a == 1'b0 && b == 1'b1, "R5 bypass capture then tdi", {62'd0, a, b}, 64'd1);
    clk(0, 0, o, oe);                 // Pause
    clk(0, 0, o, oe);
    chk(oe == 1'b0, "R9 tdoEn low in pause", {63'd0, oe}, 0);
    clk(1, 0, o, oe);                 // Exit2
    clk(0, 0, o, oe);                 // Shift again
    clk(1, 1, o, oe);
    chk(o == 1'b0 && oe == 1'b1, "R2 bit kept across pause", {62'd0, o, oe}, 64'd1);
    clk(1, 0, o, oe); clk(0, 0, o, oe);

    // R9: tdo holds across the rising edge, moves after the falling edge
    clk(1, 0, o, oe); clk(0, 0, o, oe); clk(0, 1, o, oe);   // now in Shift-DR, tdi=1
    @(negedge tck); #1; a = tdo;
    @(posedge tck); #1; b = tdo;
    chk(a == 1'b0 && b == 1'b0, "R9 tdo stable at rising edge", {62'd0, a, b}, 0);
    @(negedge tck); #1;
    chk(tdo == 1'b1, "R9 tdo moves at falling edge", {63'd0, tdo}, 1);
    tms = 1'b1;
    @(posedge tck); #1;
    clk(1, 0, o, oe); clk(0, 0, o, oe);

    // R6 R8: sample sweep over every pin pattern, shifted data never retained
    irScan(3'b100, cap);
    for (int v = 0; v < 256; v++) begin
      pins = v[7:0];
      drScan(BSR_LEN, {56'd0, ~v[7:0]}, dout, oeAll);
      chk(dout[7:0] == v[7:0], "R6 R8 sample reloads pins", dout, v);
    end
    chk(outDisable == 1'b0, "R8 sample leaves outputs enabled", {63'd0, outDisable}, 0);

    // R7 R8: sample-and-float stays high through update-dr
    irScan(3'b010, cap);
    for (int k = 0; k < 4; k++) begin
      drScan(BSR_LEN, 64'hFF >> k, dout, oeAll);
      chk(outDisable == 1'b1, "R7 R8 float held over data scans", {63'd0, outDisable}, 1);
    end

    // R1 R2: five high tms from Shift-DR reaches reset
    clk(1, 0, o, oe); clk(0, 0, o, oe); clk(0, 0, o, oe);
    for (int k = 0; k < 5; k++) clk(1, 0, o, oe);
    chk(outDisable == 1'b0, "R1 five tms ones reset instruction", {63'd0, outDisable}, 0);
    clk(0, 0, o, oe);
    chk(oe == 1'b0, "R9 tdoEn low in reset", {63'd0, oe}, 0);
    din = 64'h1234;
    drScan(33, din, dout, oeAll);
    chk(dout[32:0] == expDr(32, {32'd0, ID_EXP}, din, 33)[32:0], "R1 id after tms reset", dout, expDr(32, {32'd0, ID_EXP}, din, 33));

    // R1: asynchronous reset drops outDisable without a clock edge
    irScan(3'b010, cap);
    chk(outDisable == 1'b1, "R7 float loaded", {63'd0, outDisable}, 1);
    @(posedge tck); #2;
    trstN = 1'b0; #1;
    chk(outDisable == 1'b0, "R1 async reset clears float", {63'd0, outDisable}, 0);
    #3; trstN = 1'b1;
    clk(0, 0, o, oe);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule